// File: doc/BRIEF.md
# Indirect Management Register Access Bridge

This block sits behind one management-bus slave address and tunnels accesses into a 32 x 32 internal register space. It has two visible registers at that address. Register 0 is the command register and register 1 is the data register. A host stages write data in the data register and then writes a command word. The command word carries a 6-bit opcode, a 5-bit internal device number and a 5-bit internal register number. The bridge runs the access on a request/acknowledge register-file port. While the access is outstanding, bit 15 of the command register reads as 1.

Serial framing of the management bus is outside the block. Host accesses arrive as decoded parallel cycles: valid, write, 5-bit bus address, 5-bit register number and 16-bit data. In indirect mode the bridge answers such a cycle in the same cycle. When the strap address input is zero, the bridge steps aside and every host access goes straight through to the internal port.

Top module: `smi_indirect_bridge`

## Requirements
- R1: After reset, command readback is 0x0000, data readback is 0x0000 and `int_req` is low.
- R2: With a nonzero strap, only host cycles whose `host_phy` equals `strap_addr` are acknowledged, in the same cycle. A read of register 0 returns {busy, last accepted command bits 14:0}. A read of register 1 returns the data register. Every other register number reads as 0x0000.
- R3: A command whose bits 15:10 equal 6'b100110 (0x9800 base) starts an internal read. It targets device bits 9:5 and register bits 4:0. `int_req` rises in the cycle after the command write and stays high until `int_ack`.
- R4: A command whose bits 15:10 equal 6'b100101 (0x9400 base) starts an internal write of the data register value, with `int_we` high.
- R5: Busy rises in the cycle after an accepted command write, so an immediate readback of register 0 has bit 15 set.
- R6: Busy and `int_req` fall on the edge where `int_ack` is sampled high. For a read, `int_rdata` is captured into the data register on that same edge.
- R7: A command write while busy is ignored. The outstanding target, direction and command readback are unchanged.
- R8: A command with any other bits 15:10 is a no-op. It does not set busy, raises no request, and leaves command readback unchanged.
- R9: A write to the data register while busy is ignored.
- R10: With strap zero, `int_req`, `int_we`, `int_dev`, `int_reg` and `int_wdata` follow `host_valid`, `host_write`, `host_phy`, `host_reg` and `host_wdata`. `host_ack` and `host_rdata` follow `int_ack` and `int_rdata`, and no mailbox state is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Bridge bus address; zero selects pass-through |
| host_valid | input | 1 | Host register cycle present |
| host_write | input | 1 | Host cycle is a write |
| host_phy | input | 5 | Host bus address |
| host_reg | input | 5 | Host register number |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Host cycle accepted |
| host_rdata | output | 16 | Host read data |
| int_req | output | 1 | Internal access request |
| int_we | output | 1 | Internal access is a write |
| int_dev | output | 5 | Internal device number |
| int_reg | output | 5 | Internal register number |
| int_wdata | output | 16 | Internal write data |
| int_ack | input | 1 | Internal access done |
| int_rdata | input | 16 | Internal read data |

## Verification
Three kinds of host writes can meet an outstanding internal access: a new command, a data-register write, or a write landing in the same cycle that completes the access. The bench uses a responder with several cycles of latency, so that these host writes fall inside the busy window. A behavioural model of busy, command and data is updated on every edge. The bench compares the model against the internal port each cycle. After completion, it checks that the staged value and the stored internal word were not disturbed.

// File: rtl/sib_pkg.sv
package sib_pkg;
  parameter int DATA_W = 16;
  parameter int ADR_W  = 5;
  localparam int OPC_W = DATA_W - 2 * ADR_W;

  localparam logic [OPC_W-1:0] OPC_RD = 6'b100110;
  localparam logic [OPC_W-1:0] OPC_WR = 6'b100101;
  localparam logic [ADR_W-1:0] IDX_CMD  = 5'd0;
  localparam logic [ADR_W-1:0] IDX_DATA = 5'd1;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;

  function automatic op_e decode_op(input logic [DATA_W-1:0] word);
    logic [OPC_W-1:0] opc;
    opc = word[DATA_W-1 -: OPC_W];
    if (opc == OPC_RD) return OP_READ;
    if (opc == OPC_WR) return OP_WRITE;
    return OP_NONE;
  endfunction

  function automatic logic [ADR_W-1:0] cmd_dev(input logic [DATA_W-1:0] word);
    return word[2*ADR_W-1 -: ADR_W];
  endfunction

  function automatic logic [ADR_W-1:0] cmd_reg(input logic [DATA_W-1:0] word);
    return word[ADR_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic busy,
                                                    input logic [DATA_W-1:0] word);
    return {busy, word[DATA_W-2:0]};
  endfunction
endpackage

// File: rtl/sib_host_decode.sv
module sib_host_decode
  import sib_pkg::*;
(
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADR_W-1:0]  host_phy,
  input  logic [ADR_W-1:0]  host_reg,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADR_W-1:0]  strap_addr,
  output logic              bypass,
  output logic              hit,
  output logic              sel_cmd,
  output logic              sel_data,
  output logic              cmd_wr_evt,
  output logic              data_wr_evt,
  output op_e               op
);
  always_comb begin
    bypass      = (strap_addr == '0);
    hit         = host_valid && !bypass && (host_phy == strap_addr);
    sel_cmd     = (host_reg == IDX_CMD);
    sel_data    = (host_reg == IDX_DATA);
    cmd_wr_evt  = hit && host_write && sel_cmd;
    data_wr_evt = hit && host_write && sel_data;
    op          = decode_op(host_wdata);
  end
endmodule

// File: rtl/sib_engine.sv
module sib_engine
  import sib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_evt,
  input  logic              data_wr_evt,
  input  op_e               op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              busy,
  output logic              we_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] data_q
);
  logic launch_evt, complete_evt, ignored_cmd_evt, noop_cmd_evt, blocked_data_evt;

  assign launch_evt       = cmd_wr_evt && !busy && (op != OP_NONE);
  assign complete_evt     = busy && int_ack;
  assign ignored_cmd_evt  = cmd_wr_evt && busy;
  assign noop_cmd_evt     = cmd_wr_evt && !busy && (op == OP_NONE);
  assign blocked_data_evt = data_wr_evt && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      we_q   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
    end else if (launch_evt) begin
      busy  <= 1'b1;
      we_q  <= (op == OP_WRITE);
      cmd_q <= wdata;
    end else if (complete_evt) begin
      busy <= 1'b0;
      if (!we_q) data_q <= int_rdata;
    end else if (data_wr_evt && !busy) begin
      data_q <= wdata;
    end
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !int_ack) |=> busy);
  assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> busy);
  assert_busy_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    complete_evt |=> !busy);
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_cmd_evt |=> ($stable(cmd_q) && $stable(we_q)));
  assert_noop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    noop_cmd_evt |=> (!busy && $stable(cmd_q)));
  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_data_evt && !int_ack) |=> $stable(data_q));
endmodule

// File: rtl/smi_indirect_bridge.sv
module smi_indirect_bridge
  import sib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADR_W-1:0]  strap_addr,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADR_W-1:0]  host_phy,
  input  logic [ADR_W-1:0]  host_reg,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              int_req,
  output logic              int_we,
  output logic [ADR_W-1:0]  int_dev,
  output logic [ADR_W-1:0]  int_reg,
  output logic [DATA_W-1:0] int_wdata,
  input  logic              int_ack,
  input  logic [DATA_W-1:0] int_rdata
);
  logic bypass, hit, sel_cmd, sel_data, cmd_wr_evt, data_wr_evt;
  op_e  op;
  logic busy, we_q;
  logic [DATA_W-1:0] cmd_q, data_q;

  sib_host_decode u_dec (
    .host_valid (host_valid), .host_write (host_write), .host_phy (host_phy),
    .host_reg (host_reg), .host_wdata (host_wdata), .strap_addr (strap_addr),
    .bypass (bypass), .hit (hit), .sel_cmd (sel_cmd), .sel_data (sel_data),
    .cmd_wr_evt (cmd_wr_evt), .data_wr_evt (data_wr_evt), .op (op)
  );

  sib_engine u_eng (
    .clk (clk), .rst_n (rst_n), .cmd_wr_evt (cmd_wr_evt), .data_wr_evt (data_wr_evt),
    .op (op), .wdata (host_wdata), .int_ack (int_ack), .int_rdata (int_rdata),
    .busy (busy), .we_q (we_q), .cmd_q (cmd_q), .data_q (data_q)
  );

  always_comb begin
    if (bypass) begin
      int_req    = host_valid;
      int_we     = host_write;
      int_dev    = host_phy;
      int_reg    = host_reg;
      int_wdata  = host_wdata;
      host_ack   = int_ack;
      host_rdata = int_rdata;
    end else begin
      int_req   = busy;
      int_we    = we_q;
      int_dev   = cmd_dev(cmd_q);
      int_reg   = cmd_reg(cmd_q);
      int_wdata = data_q;
      host_ack  = hit;
      if (hit && sel_cmd)       host_rdata = status_word(busy, cmd_q);
      else if (hit && sel_data) host_rdata = data_q;
      else                      host_rdata = '0;
    end
  end

  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !busy) |-> !int_req);
  assert_req_target_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && int_req && !int_ack) |=> (int_req && $stable(int_dev) && $stable(int_reg)));
endmodule

// File: tb/smi_indirect_bridge_tb.sv
module smi_indirect_bridge_tb;
  localparam int LAT = 4;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [4:0] strap_addr = 5'd3;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [4:0] host_phy = '0, host_reg = '0;
  logic [15:0] host_wdata = '0;
  logic host_ack, int_req, int_we;
  logic [15:0] host_rdata, int_wdata;
  logic [4:0] int_dev, int_reg;
  logic int_ack;
  logic [15:0] int_rdata;

  smi_indirect_bridge u_dut (
    .clk (clk), .rst_n (rst_n), .strap_addr (strap_addr),
    .host_valid (host_valid), .host_write (host_write), .host_phy (host_phy),
    .host_reg (host_reg), .host_wdata (host_wdata), .host_ack (host_ack),
    .host_rdata (host_rdata), .int_req (int_req), .int_we (int_we),
    .int_dev (int_dev), .int_reg (int_reg), .int_wdata (int_wdata),
    .int_ack (int_ack), .int_rdata (int_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mem [0:1023];
  int rcnt;

  function automatic logic [15:0] init_val(input int i);
    return (16'(i) * 16'h0101) ^ 16'h5A5A;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // internal register-file responder
  initial begin
    int_ack = 1'b0; int_rdata = '0; rcnt = 0;
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    forever begin
      @(posedge clk);
      if (!rst_n) begin int_ack <= 1'b0; rcnt <= 0; end
      else if (int_ack) int_ack <= 1'b0;
      else if (int_req) begin
        if (rcnt == LAT) begin
          int_ack   <= 1'b1;
          int_rdata <= mem[{int_dev, int_reg}];
          if (int_we) mem[{int_dev, int_reg}] <= int_wdata;
          rcnt <= 0;
        end else rcnt <= rcnt + 1;
      end
    end
  end

  // behavioural reference of the mailbox
  bit m_busy = 0, m_we = 0;
  logic [15:0] m_cmd = '0, m_data = '0;
  initial forever begin
    @(posedge clk);
    if (!rst_n) begin m_busy = 0; m_we = 0; m_cmd = '0; m_data = '0; end
    else if (strap_addr != 0) begin
      if (m_busy && int_ack) begin
        m_busy = 0;
        if (!m_we) m_data = int_rdata;
      end else if (host_valid && host_write && host_phy == strap_addr && !m_busy) begin
        if (host_reg == 0) begin
          if (host_wdata[15:10] == 6'h26) begin m_busy = 1; m_we = 0; m_cmd = host_wdata; end
          else if (host_wdata[15:10] == 6'h25) begin m_busy = 1; m_we = 1; m_cmd = host_wdata; end
        end else if (host_reg == 1) m_data = host_wdata;
      end
    end
  end

  // per-cycle comparison, one time unit after the falling edge
  initial forever begin
    @(posedge clk); #3;
    if (rst_n && !done) begin
      if (strap_addr != 0) begin
        check("R3 R6 int_req vs model busy", {15'd0, int_req}, {15'd0, m_busy});
        if (m_busy) begin
          check("R3 R4 R7 int_we", {15'd0, int_we}, {15'd0, m_we});
          check("R3 R7 int target", {6'd0, int_dev, int_reg}, {6'd0, m_cmd[9:0]});
          if (m_we) check("R4 int_wdata", int_wdata, m_data);
        end
      end else begin
        check("R10 int_req follows host_valid", {15'd0, int_req}, {15'd0, host_valid});
        if (host_valid) check("R10 target follows host", {6'd0, int_dev, int_reg}, {6'd0, host_phy, host_reg});
      end
    end
  end

  // one host cycle; entered and left at a falling edge
  task automatic xfer(input logic wr, input logic [4:0] phy, input logic [4:0] rn,
                      input logic [15:0] wd, output logic [15:0] rd);
    host_valid = 1'b1; host_write = wr; host_phy = phy; host_reg = rn; host_wdata = wd;
    #1;
    while (!host_ack) begin @(negedge clk); #1; end
    rd = host_rdata;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic wait_idle(input logic [4:0] phy);
    logic [15:0] r;
    for (int k = 0; k < 40; k++) begin
      xfer(1'b0, phy, 5'd0, 16'h0, r);
      if (!r[15]) return;
    end
    check("R6 busy never cleared", 16'h1, 16'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    @(negedge clk);
    do_reset();
    // R1 reset state
    xfer(1'b0, 5'd3, 5'd0, 16'h0, r); check("R1 command readback", r, 16'h0000);
    xfer(1'b0, 5'd3, 5'd1, 16'h0, r); check("R1 data readback", r, 16'h0000);
    check("R1 int_req low", {15'd0, int_req}, 16'h0);
    // R2 address match
    host_valid = 1'b1; host_write = 1'b0; host_phy = 5'd7; host_reg = 5'd0;
    #1 check("R2 foreign address not acked", {15'd0, host_ack}, 16'h0);
    @(negedge clk); host_valid = 1'b0;
    xfer(1'b0, 5'd3, 5'd5, 16'h0, r); check("R2 other register reads zero", r, 16'h0000);
    xfer(1'b1, 5'd3, 5'd1, 16'hBEEF, r);
    xfer(1'b0, 5'd3, 5'd1, 16'h0, r); check("R2 data register readback", r, 16'hBEEF);
    // R4 write command, with collisions during busy
    xfer(1'b1, 5'd3, 5'd0, 16'h9400 | (16'd4 << 5) | 16'd9, r);
    xfer(1'b0, 5'd3, 5'd0, 16'h0, r); check("R5 immediate readback busy", r, 16'h9489);
    xfer(1'b1, 5'd3, 5'd1, 16'h1111, r);
    xfer(1'b1, 5'd3, 5'd0, 16'h9800 | (16'd2 << 5) | 16'd17, r);
    xfer(1'b0, 5'd3, 5'd0, 16'h0, r); check("R7 command ignored while busy", r, 16'h9489);
    wait_idle(5'd3);
    xfer(1'b0, 5'd3, 5'd1, 16'h0, r); check("R9 data write while busy ignored", r, 16'hBEEF);
    check("R4 internal word written", mem[4*32+9], 16'hBEEF);
    check("R7 ignored read did not run", mem[2*32+17], init_val(2*32+17));
    // R3 read command
    xfer(1'b1, 5'd3, 5'd0, 16'h9800 | (16'd2 << 5) | 16'd17, r);
    wait_idle(5'd3);
    xfer(1'b0, 5'd3, 5'd1, 16'h0, r); check("R3 R6 read result", r, init_val(2*32+17));
    xfer(1'b0, 5'd3, 5'd0, 16'h0, r); check("R6 busy clear readback", r, 16'h1851);
    // R8 no-op opcode
    xfer(1'b1, 5'd3, 5'd0, 16'hA000 | 16'd5, r);
    xfer(1'b0, 5'd3, 5'd0, 16'h0, r); check("R8 no-op leaves command idle", r, 16'h1851);
    check("R8 no request", {15'd0, int_req}, 16'h0);
    // R10 pass-through with strap zero
    strap_addr = 5'd0;
    do_reset();
    xfer(1'b1, 5'd6, 5'd2, 16'hCAFE, r);
    check("R10 direct write lands", mem[6*32+2], 16'hCAFE);
    xfer(1'b0, 5'd6, 5'd2, 16'h0, r); check("R10 direct read", r, 16'hCAFE);
    xfer(1'b1, 5'd0, 5'd0, 16'h9800, r);
    check("R10 register 0 is plain storage", mem[0], 16'h9800);
    xfer(1'b0, 5'd0, 5'd0, 16'h0, r); check("R10 register 0 readback", r, 16'h9800);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule